// File: doc/BRIEF.md
# TDM Frame-Aligned DMA Request Sequencer

This block paces DMA handshakes for a time-division-multiplexed local channel space. A frame is cut into timeslots of `SLOT_CYCLES` clock cycles, and every timeslot carries four byte channels. A per-channel enable vector from connection memory marks which channels take part. One enable bit serves both directions, so an enabled channel is moved out of the block and into it in every frame.

For each timeslot with at least one enabled channel, the sequencer raises a read request (active low) when the slot opens. It raises a write request (active low) when the slot closes, and that request runs through the following slot. Each request is held low until the external controller has acknowledged one transfer per enabled channel. During each acknowledged cycle the block presents the 7-bit channel index, so the datapath can steer the byte. A burst whose acknowledges have not all arrived when its window closes is dropped, and a sticky overrun flag is set for that direction.

The global enable is sampled only on a frame sync, so transfers always begin on a frame boundary. In the first frame after arming, timeslot 0 is reserved for preparation and gets no requests. Its channels are served from the second frame onward. Frame sync is expected on the last cycle of the last timeslot.

Top module: `tdmdma_seq`

## Requirements
- R1: After reset both request outputs are high, no transfer strobe is active and both overrun flags are 0.
- R2: The global enable is sampled only on the cycle that frame_sync is high. A change between syncs has no effect on the requests until the next frame begins. While disarmed, the read request stays high.
- R3: A timeslot is numbered so that its first cycle is cycle 0. In an armed timeslot with enabled channels, the read request goes low in cycle 1, after the slot opening was registered.
- R4: For an armed timeslot with enabled channels, the write request goes low in cycle 0 of the following timeslot.
- R5: A request stays low until as many acknowledged cycles (acknowledge low) have occurred as there are enabled channels in its slot, which is at most four. It then returns high on the next cycle. A transfer strobe is only ever active while its request is low.
- R6: Channel n belongs to timeslot n/4 at position n%4, and is enabled by bit n of ce_mask. Within a burst, channels are transferred in ascending order. The channel output is {timeslot, position}.
- R7: A timeslot with no enabled channel produces no read request and no write request.
- R8: In the first frame after arming, timeslot 0 produces no request in either direction. In the next frame it is served normally.
- R9: A read burst whose transfers are incomplete at the last cycle of its slot is dropped, and its request goes high. The same holds for a write burst at the last cycle of the following slot. The flag of that direction is then set and stays set until reset. The flag of the other direction is unaffected.
- R10: The write transfers of each frame cover exactly the same channel sequence as the read transfers, since one enable bit covers both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | High on the last cycle of a frame; the next cycle opens timeslot 0 |
| dma_en | input | 1 | Global DMA enable, sampled at frame sync |
| ce_mask | input | 128 | Per-channel enable, bit n for channel n |
| dack_rd_n | input | 1 | Read acknowledge, active low |
| dack_wr_n | input | 1 | Write acknowledge, active low |
| dreq_rd_n | output | 1 | Read request, active low |
| dreq_wr_n | output | 1 | Write request, active low |
| rd_xfer | output | 1 | A read transfer happens this cycle |
| rd_chan | output | 7 | Channel index of the current read transfer |
| wr_xfer | output | 1 | A write transfer happens this cycle |
| wr_chan | output | 7 | Channel index of the current write transfer |
| rd_overrun | output | 1 | Sticky flag: a read burst was dropped |
| wr_overrun | output | 1 | Sticky flag: a write burst was dropped |

## Verification
A stale slot or cycle count misplaces the falling edge of a request within the same slot. It also tags the very next transfer with the channel index of a neighbouring slot. A corrupted remaining-channel mask shortens or lengthens a burst by a cycle, or skips a channel in the ascending order. This shows within one slot on the request width and in the scoreboard order. A wrong arming or preparation state appears from the first slot of a frame, as a request where none is due or the lack of one. A missed drop at a window edge keeps a request low into cycle 0 of the next slot and leaves the overrun flag at 0.

// File: rtl/tdmdma_pkg.sv
package tdmdma_pkg;
  // four byte channels share one 2 Mb/s timeslot in every stream mode
  localparam int CH_PER_SLOT = 4;
  localparam int SUB_W       = $clog2(CH_PER_SLOT);

  typedef logic [CH_PER_SLOT-1:0] slot_mask_t;

  // lowest enabled position in a slot mask (0 when empty)
  function automatic logic [SUB_W-1:0] first_set(input slot_mask_t m);
    logic [SUB_W-1:0] r;
    r = '0;
    for (int i = CH_PER_SLOT - 1; i >= 0; i--)
      if (m[i]) r = SUB_W'(i);
    return r;
  endfunction

  // mask with one position removed
  function automatic slot_mask_t clear_pos(input slot_mask_t m, input logic [SUB_W-1:0] p);
    return m & ~(slot_mask_t'(1) << p);
  endfunction
endpackage

// File: rtl/tdmdma_slot_timer.sv
module tdmdma_slot_timer #(
  parameter int NUM_SLOTS   = 32,
  parameter int SLOT_CYCLES = 16,
  parameter int SLOT_W      = $clog2(NUM_SLOTS),
  parameter int CYC_W       = $clog2(SLOT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync_i,
  input  logic              dma_en_i,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              armed_o,
  output logic              prep_o,
  output logic              slot_first_o,
  output logic              slot_last_o
);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q;
  logic              armed_q, prep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      slot_q  <= '0;
      armed_q <= 1'b0;
      prep_q  <= 1'b0;
    end else if (frame_sync_i) begin
      cyc_q   <= '0;
      slot_q  <= '0;
      armed_q <= dma_en_i;
      prep_q  <= dma_en_i & ~armed_q;
    end else if (cyc_q == CYC_LAST) begin
      cyc_q  <= '0;
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + SLOT_W'(1);
    end else begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  assign cyc_o        = cyc_q;
  assign slot_o       = slot_q;
  assign armed_o      = armed_q;
  assign prep_o       = prep_q;
  assign slot_first_o = (cyc_q == '0);
  assign slot_last_o  = (cyc_q == CYC_LAST);
endmodule

// File: rtl/tdmdma_burst.sv
module tdmdma_burst
  import tdmdma_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  slot_mask_t              mask_i,
  input  logic                    drop_i,
  input  logic                    dack_n_i,
  output logic                    dreq_n_o,
  output logic                    xfer_o,
  output logic [SLOT_W+SUB_W-1:0] chan_o,
  output logic                    overrun_o
);
  logic              busy_q, ovr_q;
  slot_mask_t        rem_q, rem_nxt;
  logic [SLOT_W-1:0] slot_q;
  logic [SUB_W-1:0]  sub;
  logic              xfer, done, abandon;

  always_comb begin
    sub     = first_set(rem_q);
    xfer    = busy_q & ~dack_n_i;
    rem_nxt = xfer ? clear_pos(rem_q, sub) : rem_q;
    done    = xfer && (rem_nxt == '0);
    abandon = busy_q && drop_i && !done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
      rem_q  <= '0;
      slot_q <= '0;
    end else begin
      if (abandon) ovr_q <= 1'b1;
      if (start_i) begin
        busy_q <= 1'b1;
        rem_q  <= mask_i;
        slot_q <= slot_i;
      end else begin
        rem_q <= rem_nxt;
        if (done || drop_i) busy_q <= 1'b0;
      end
    end
  end

  assign dreq_n_o  = ~busy_q;
  assign xfer_o    = xfer;
  assign chan_o    = {slot_q, sub};
  assign overrun_o = ovr_q;
endmodule

// File: rtl/tdmdma_seq.sv
module tdmdma_seq
  import tdmdma_pkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int SLOT_CYCLES = 16,
  parameter int NUM_CH      = NUM_SLOTS * CH_PER_SLOT,
  parameter int CHAN_W      = $clog2(NUM_SLOTS) + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              dma_en,
  input  logic [NUM_CH-1:0] ce_mask,
  input  logic              dack_rd_n,
  input  logic              dack_wr_n,
  output logic              dreq_rd_n,
  output logic              dreq_wr_n,
  output logic              rd_xfer,
  output logic [CHAN_W-1:0] rd_chan,
  output logic              wr_xfer,
  output logic [CHAN_W-1:0] wr_chan,
  output logic              rd_overrun,
  output logic              wr_overrun
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int CYC_W  = $clog2(SLOT_CYCLES);
  localparam int DIR_WR = 0;
  localparam int DIR_RD = 1;

  logic [CYC_W-1:0]  cyc;
  logic [SLOT_W-1:0] slot;
  logic              armed, prep, slot_first, slot_last;
  slot_mask_t        slot_mask;
  logic              eligible;
  logic [1:0]        start_v, dack_v, dreq_v, xfer_v, ovr_v;
  logic [CHAN_W-1:0] chan_v [2];

  tdmdma_slot_timer #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_CYCLES(SLOT_CYCLES), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_sync_i(frame_sync), .dma_en_i(dma_en),
    .cyc_o(cyc), .slot_o(slot), .armed_o(armed), .prep_o(prep),
    .slot_first_o(slot_first), .slot_last_o(slot_last)
  );

  // the four enable bits of the current timeslot
  assign slot_mask = ce_mask[int'(slot) * CH_PER_SLOT +: CH_PER_SLOT];
  // timeslot 0 of the first armed frame is reserved for preparation
  assign eligible  = armed && !(prep && slot == '0) && (slot_mask != '0);

  assign start_v[DIR_RD] = eligible && slot_first;
  assign start_v[DIR_WR] = eligible && slot_last;
  assign dack_v[DIR_RD]  = dack_rd_n;
  assign dack_v[DIR_WR]  = dack_wr_n;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    tdmdma_burst #(.SLOT_W(SLOT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start_i(start_v[d]), .slot_i(slot),
      .mask_i(slot_mask), .drop_i(slot_last), .dack_n_i(dack_v[d]),
      .dreq_n_o(dreq_v[d]), .xfer_o(xfer_v[d]), .chan_o(chan_v[d]),
      .overrun_o(ovr_v[d])
    );
  end

  assign dreq_rd_n  = dreq_v[DIR_RD];
  assign dreq_wr_n  = dreq_v[DIR_WR];
  assign rd_xfer    = xfer_v[DIR_RD];
  assign wr_xfer    = xfer_v[DIR_WR];
  assign rd_chan    = chan_v[DIR_RD];
  assign wr_chan    = chan_v[DIR_WR];
  assign rd_overrun = ovr_v[DIR_RD];
  assign wr_overrun = ovr_v[DIR_WR];
endmodule

// File: rtl/tdmdma_seq_chk.sv
module tdmdma_seq_chk #(
  parameter int SLOT_W      = 5,
  parameter int CYC_W       = 4,
  parameter int CHAN_W      = 7,
  parameter int SLOT_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreq_rd_n,
  input logic              dreq_wr_n,
  input logic              rd_xfer,
  input logic              wr_xfer,
  input logic [CHAN_W-1:0] rd_chan,
  input logic              rd_overrun,
  input logic              wr_overrun,
  input logic [CYC_W-1:0]  cyc,
  input logic [SLOT_W-1:0] slot,
  input logic              armed,
  input logic              prep
);
  a_r2_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> dreq_rd_n);

  a_r3_read_opens_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dreq_rd_n) |-> $past(cyc) == '0);

  a_r4_write_closes_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dreq_wr_n) |-> $past(cyc) == CYC_W'(SLOT_CYCLES - 1));

  a_r5_rd_xfer_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xfer |-> !dreq_rd_n);

  a_r5_wr_xfer_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_xfer |-> !dreq_wr_n);

  a_r6_rd_chan_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xfer |-> rd_chan[CHAN_W-1:CHAN_W-SLOT_W] == slot);

  a_r8_prep_slot0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prep && slot == '0) |-> dreq_rd_n);

  a_r9_rd_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_overrun |=> rd_overrun);

  a_r9_wr_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overrun |=> wr_overrun);
endmodule

bind tdmdma_seq tdmdma_seq_chk #(
  .SLOT_W(SLOT_W), .CYC_W(CYC_W), .CHAN_W(CHAN_W), .SLOT_CYCLES(SLOT_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .dreq_rd_n(dreq_rd_n), .dreq_wr_n(dreq_wr_n),
  .rd_xfer(rd_xfer), .wr_xfer(wr_xfer), .rd_chan(rd_chan),
  .rd_overrun(rd_overrun), .wr_overrun(wr_overrun),
  .cyc(cyc), .slot(slot), .armed(armed), .prep(prep)
);

// File: tb/tdmdma_seq_tb_top.sv
module tdmdma_seq_tb_top;
  localparam int NS = 32, SC = 16, FR = NS * SC, NCH = NS * 4;

  logic           clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0, dma_en = 1'b0;
  logic [NCH-1:0] ce_mask = '0;
  logic           dack_rd_n = 1'b1, dack_wr_n = 1'b1;
  logic           dreq_rd_n, dreq_wr_n, rd_xfer, wr_xfer, rd_overrun, wr_overrun;
  logic [6:0]     rd_chan, wr_chan;

  tdmdma_seq #(.NUM_SLOTS(NS), .SLOT_CYCLES(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .dma_en(dma_en),
    .ce_mask(ce_mask), .dack_rd_n(dack_rd_n), .dack_wr_n(dack_wr_n),
    .dreq_rd_n(dreq_rd_n), .dreq_wr_n(dreq_wr_n), .rd_xfer(rd_xfer),
    .rd_chan(rd_chan), .wr_xfer(wr_xfer), .wr_chan(wr_chan),
    .rd_overrun(rd_overrun), .wr_overrun(wr_overrun)
  );

  always #10 clk = ~clk;

  int  checks = 0, fails = 0;
  bit  done = 0;
  int  rd_q[$], wr_q[$];
  int  e_rd, e_wr;
  bit  armed_m = 0, prep_m = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [NCH-1:0] make_mask(input int pat);
    logic [NCH-1:0] m;
    for (int n = 0; n < NCH; n++) begin
      case (pat)
        0:       m[n] = (n % 3 == 0);
        1:       m[n] = (n % 5 == 1) || (n >= 8 && n < 12);
        default: m[n] = (n < 8) || (n >= 120);
      endcase
    end
    return m;
  endfunction

  function automatic int slot_count(input int s);
    int k = 0;
    for (int b = 0; b < 4; b++) if (ce_mask[s*4 + b]) k++;
    return k;
  endfunction

  function automatic bit elig(input int s);
    return armed_m && !(prep_m && s == 0);
  endfunction

  function automatic string tag(input int s, input int k, input bit ack, input string normal);
    if (!armed_m) return "R2";
    if (prep_m && s == 0) return "R8";
    if (k == 0) return "R7";
    if (!ack) return "R9";
    return normal;
  endfunction

  // scoreboard monitor: compare every transfer against the predicted order
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_xfer) begin
        if (rd_q.size() == 0) check(0, "R2", "unexpected read transfer", int'(rd_chan), -1);
        else begin
          e_rd = rd_q.pop_front();
          check(int'(rd_chan) == e_rd, "R6", "read channel order", int'(rd_chan), e_rd);
        end
      end
      if (wr_xfer) begin
        if (wr_q.size() == 0) check(0, "R10", "unexpected write transfer", int'(wr_chan), -1);
        else begin
          e_wr = wr_q.pop_front();
          check(int'(wr_chan) == e_wr, "R10", "write channel order", int'(wr_chan), e_wr);
        end
      end
    end
  end

  // one frame: start in cycle 0 of timeslot 0, end after the frame sync edge
  task automatic run_frame(input int pat, input bit rd_ack, input int en_at, input bit en_val);
    bit exp_rd, exp_wr;
    frame_sync = 1'b0;
    ce_mask    = make_mask(pat);
    dack_rd_n  = !rd_ack;
    if (armed_m)
      for (int s = 0; s < NS; s++)
        if (elig(s))
          for (int b = 0; b < 4; b++)
            if (ce_mask[s*4 + b]) begin
              if (rd_ack) rd_q.push_back(s*4 + b);
              wr_q.push_back(s*4 + b);
            end
    for (int i = 0; i < FR; i++) begin
      int s = i / SC, c = i % SC, k = slot_count(s);
      if (i == en_at) dma_en = en_val;
      exp_rd = !(elig(s) && k > 0 && c >= 1 && (rd_ack ? c <= k : 1'b1));
      check(dreq_rd_n == exp_rd, tag(s, k, rd_ack, (c == 1) ? "R3" : "R5"),
            "read request level", int'(dreq_rd_n), int'(exp_rd));
      if (i >= SC) begin
        int p = s - 1, kp = slot_count(s - 1);
        exp_wr = !(elig(p) && kp > 0 && c < kp);
        check(dreq_wr_n == exp_wr, tag(p, kp, 1'b1, (c == 0) ? "R4" : "R5"),
              "write request level", int'(dreq_wr_n), int'(exp_wr));
      end
      frame_sync = (i == FR - 1);
      tick();
    end
    frame_sync = 1'b0;
    prep_m  = dma_en && !armed_m;
    armed_m = dma_en;
  endtask

  initial begin
    dack_wr_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();
    check(dreq_rd_n == 1'b1, "R1", "read request after reset", int'(dreq_rd_n), 1);
    check(dreq_wr_n == 1'b1, "R1", "write request after reset", int'(dreq_wr_n), 1);
    check(rd_overrun == 1'b0 && wr_overrun == 1'b0, "R1", "overrun flags after reset",
          int'({rd_overrun, wr_overrun}), 0);
    check(rd_xfer == 1'b0 && wr_xfer == 1'b0, "R1", "strobes after reset",
          int'({rd_xfer, wr_xfer}), 0);
    frame_sync = 1'b1;
    tick();
    run_frame(0, 1'b1, 100, 1'b1); // R2: enable raised mid-frame, no effect yet
    run_frame(0, 1'b1, -1, 1'b0);  // R8: preparation frame, slot 0 quiet
    run_frame(0, 1'b1, -1, 1'b0);  // R8: slot 0 served now
    run_frame(1, 1'b1, -1, 1'b0);  // R5 R7: full slot and empty slots
    check(rd_overrun == 1'b0, "R9", "no read overrun while acknowledged", int'(rd_overrun), 0);
    run_frame(1, 1'b0, -1, 1'b0);  // R9: read acknowledge withheld
    check(rd_overrun == 1'b1, "R9", "read overrun after dropped bursts", int'(rd_overrun), 1);
    check(wr_overrun == 1'b0, "R9", "write flag untouched", int'(wr_overrun), 0);
    run_frame(2, 1'b1, 200, 1'b0); // R2: enable dropped mid-frame, still armed
    run_frame(2, 1'b1, -1, 1'b0);  // R2: disarmed frame
    tick();
    check(rd_q.size() == 0, "R5", "pending read transfers", rd_q.size(), 0);
    check(wr_q.size() == 0, "R10", "pending write transfers", wr_q.size(), 0);
    check(rd_overrun == 1'b1, "R9", "read overrun stays set", int'(rd_overrun), 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule